// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filtering

This block turns an asynchronous serial receive line into parallel frames. A sample tick from an external rate generator runs at 16, 8, 6 or 4 times the bit rate. On every tick the block takes one sample of the synchronised and optionally inverted line. It finds the start bit and then decides each bit either by a 3-sample majority vote around the bit centre or by the single centre sample. Data bits, an optional parity bit and the first stop bit follow in that order.

Each completed frame leaves the block as a one-cycle strobe. The strobe carries a 9-bit word and the parity-error and framing-error flags of that frame. A gate after the framer can discard frames. A receive block, set and cleared by pulses, drops ordinary frames. In multiprocessor mode, a frame whose top word bit matches a configured value still passes and is marked as an address frame. Frames with a parity error can also be dropped on request. An idle output shows when no frame is being assembled. Storage, baud generation and bus access belong to the surrounding logic.

Top module: `ovs_serial_rx`

## Requirements
- R1: After reset `rx_idle` is 1, `frame_valid` is 0 and `frame_data` is 0.
- R2: `os_sel` sets the ticks per bit: code 0 gives 16, code 1 gives 8, code 2 gives 6, code 3 gives 4. The strobe follows the tick that takes the deciding stop-bit sample. That tick lies (bits before stop) × ratio + ratio/2 ticks after the start tick, plus one more tick when voting is on.
- R3: In idle, a tick whose sample is 0 after a sample of 1 starts a frame and drops `rx_idle`. If the start bit decides as 1 at its centre, the frame is abandoned, `rx_idle` returns to 1 and no strobe is given.
- R4: With `vote_off` = 0, each bit is the majority of samples ratio/2−1, ratio/2 and ratio/2+1 of the bit, so a flip of the centre sample alone has no effect. With `vote_off` = 1, only sample ratio/2 decides.
- R5: `width_sel` code 1 gives 7 data bits, code 3 gives 9 and codes 0 and 2 give 8. Bits arrive least significant first and are zero-extended into `frame_data`.
- R6: `par_sel` code 2 adds an even-parity bit and code 3 an odd-parity bit after the data. Codes 0 and 1 send no parity bit. `frame_par_err` is 1 when the received parity bit is wrong.
- R7: `stop_sel` code 0 checks no stop bit. Codes 1, 2 and 3 check only the first stop bit. `frame_frm_err` is 1 when a checked stop bit decides as 0.
- R8: With `rx_invert` = 1 the line is inverted before sampling, so the idle level becomes 0.
- R9: A `block_set` pulse blocks reception and a `block_clear` pulse unblocks it; set wins if both are high. While blocked, frames that are not address frames give no strobe.
- R10: With `mp_enable` = 1, a frame whose `frame_data` bit 8 equals `mp_addr_bit` is an address frame. It is delivered even while blocked, and its strobe comes with `frame_is_addr` = 1.
- R11: With `skip_par_err` = 1, frames with a parity error give no strobe.
- R12: `frame_valid` is high for exactly one clock per delivered frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial receive line, asynchronous |
| os_tick | input | 1 | One-cycle sample tick at the oversampling rate |
| os_sel | input | 2 | Oversampling ratio code |
| vote_off | input | 1 | 1 disables the 3-sample majority vote |
| width_sel | input | 2 | Data width code |
| par_sel | input | 2 | Parity mode code |
| stop_sel | input | 2 | Stop-bit mode code |
| rx_invert | input | 1 | Invert line before sampling |
| mp_enable | input | 1 | Enable address-frame detection |
| mp_addr_bit | input | 1 | Bit 8 value that marks an address frame |
| skip_par_err | input | 1 | Drop frames with a parity error |
| block_set | input | 1 | Pulse to block reception |
| block_clear | input | 1 | Pulse to unblock reception |
| frame_valid | output | 1 | One-cycle frame strobe |
| frame_data | output | 9 | Received word |
| frame_par_err | output | 1 | Parity error of this frame |
| frame_frm_err | output | 1 | Framing error of this frame |
| frame_is_addr | output | 1 | This frame is an address frame |
| rx_idle | output | 1 | No frame in progress |

## Verification
A line change reaches the sampler two clocks after it is driven. The bench therefore changes the line just after each tick edge, and every change is sampled by the following tick. The framer's state, and with it `rx_idle`, changes on the tick edge that takes the start sample or the abandoning sample. The frame strobe is due one clock after the tick that takes the deciding stop sample. The scoreboard records for every frame the tick number at which that stop decision must fall and compares it with the bench's own tick counter when the strobe appears. Idle checks are made one nanosecond after the tick edge concerned.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
  localparam int WORD_W  = 9;
  localparam int MAX_OVS = 16;
  localparam int CNT_W   = $clog2(MAX_OVS + 1);
  localparam int IDX_W   = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP} fr_state_e;
  typedef enum logic [1:0] {STOP_HALF = 2'd0, STOP_ONE = 2'd1,
                            STOP_ONE_HALF = 2'd2, STOP_TWO = 2'd3} stop_mode_e;
  typedef enum logic [1:0] {PAR_OFF = 2'd0, PAR_RSVD = 2'd1,
                            PAR_EVEN = 2'd2, PAR_ODD = 2'd3} par_mode_e;

  // ticks per bit for an oversampling code
  function automatic logic [CNT_W-1:0] ovs_ratio(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(16);
      2'd1:    return CNT_W'(8);
      2'd2:    return CNT_W'(6);
      default: return CNT_W'(4);
    endcase
  endfunction

  // tick index within a bit at which the bit value is decided
  function automatic logic [CNT_W-1:0] decide_point(input logic [1:0] code, input logic no_vote);
    return (ovs_ratio(code) >> 1) + CNT_W'(!no_vote);
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [IDX_W-1:0] frame_len(input logic [1:0] code);
    case (code)
      2'd1:    return IDX_W'(7);
      2'd3:    return IDX_W'(9);
      default: return IDX_W'(8);
    endcase
  endfunction

  function automatic logic parity_on(input logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

  function automatic logic parity_fault(input logic [1:0] mode, input logic [WORD_W-1:0] data,
                                        input logic pbit);
    logic ones_odd;
    ones_odd = (^data) ^ pbit;
    case (mode)
      PAR_EVEN: return ones_odd;
      PAR_ODD:  return ~ones_odd;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic stop_checked(input logic [1:0] mode);
    return mode != STOP_HALF;
  endfunction
endpackage

// File: rtl/ovs_rx_sampler.sv
module ovs_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic invert,
  input  logic tick,
  output logic samp_now,
  output logic samp_prev,
  output logic samp_vote
);
  import ovs_rx_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= line_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= sync_q[g-1];
    end
  end

  assign samp_now  = sync_q[SYNC_STAGES-1] ^ invert;
  assign samp_prev = hist_q[0];
  assign samp_vote = vote3(hist_q[1], hist_q[0], samp_now);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    hist_q <= 2'b11;
    else if (tick) hist_q <= {hist_q[0], samp_now};

  AST_HISTORY_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hist_q)); // R4
endmodule

// File: rtl/ovs_rx_framer.sv
module ovs_rx_framer
  import ovs_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              samp_now,
  input  logic              samp_prev,
  input  logic              samp_vote,
  input  logic [1:0]        os_sel,
  input  logic              vote_off,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        par_sel,
  input  logic [1:0]        stop_sel,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              perr,
  output logic              ferr,
  output logic              idle
);
  fr_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, ratio, dec_pt;
  logic [IDX_W-1:0]  idx_q, len;
  logic [WORD_W-1:0] acc_q;
  logic              par_q, bit_val, at_dec, at_end;
  logic              start_seen, start_abort;

  always_comb begin
    ratio       = ovs_ratio(os_sel);
    dec_pt      = decide_point(os_sel, vote_off);
    len         = frame_len(width_sel);
    bit_val     = vote_off ? samp_now : samp_vote;
    at_dec      = (cnt_q == dec_pt);
    at_end      = (cnt_q == ratio - 1'b1);
    start_seen  = tick && (state_q == FR_IDLE) && samp_prev && !samp_now;
    start_abort = tick && (state_q == FR_START) && at_dec && bit_val;
  end

  assign idle = (state_q == FR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
      par_q   <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        unique case (state_q)
          FR_IDLE: begin
            cnt_q <= CNT_W'(1);
            if (start_seen) begin
              state_q <= FR_START;
              acc_q   <= '0;
              idx_q   <= '0;
            end
          end
          FR_START: begin
            if (start_abort)  state_q <= FR_IDLE;
            else if (at_end)  state_q <= FR_DATA;
          end
          FR_DATA: begin
            if (at_dec) acc_q[idx_q] <= bit_val;
            if (at_end) begin
              if (idx_q == len - 1'b1) state_q <= parity_on(par_sel) ? FR_PAR : FR_STOP;
              else                     idx_q   <= idx_q + 1'b1;
            end
          end
          FR_PAR: begin
            if (at_dec) par_q   <= bit_val;
            if (at_end) state_q <= FR_STOP;
          end
          FR_STOP: begin
            if (at_dec) begin
              done    <= 1'b1;
              word    <= acc_q;
              perr    <= parity_fault(par_sel, acc_q, par_q);
              ferr    <= stop_checked(stop_sel) && !bit_val;
              state_q <= FR_IDLE;
            end
          end
          default: state_q <= FR_IDLE;
        endcase
      end
    end
  end

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(tick)); // R3
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |=> (idle && !done)); // R3
  AST_HALF_STOP_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(stop_sel) == STOP_HALF) |-> !ferr); // R7
  AST_NO_PARITY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !parity_on($past(par_sel))) |-> !perr); // R6
endmodule

// File: rtl/ovs_rx_gate.sv
module ovs_rx_gate
  import ovs_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              perr,
  input  logic              ferr,
  input  logic              blk_set,
  input  logic              blk_clr,
  input  logic              mp_en,
  input  logic              mp_bit,
  input  logic              skip_perr,
  output logic              frame_valid,
  output logic [WORD_W-1:0] frame_data,
  output logic              frame_perr,
  output logic              frame_ferr,
  output logic              frame_addr
);
  logic blocked_q, is_addr, keep;

  assign is_addr = mp_en && (word[WORD_W-1] == mp_bit);
  assign keep    = done && (!blocked_q || is_addr) && !(skip_perr && perr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked_q   <= 1'b0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
      frame_perr  <= 1'b0;
      frame_ferr  <= 1'b0;
      frame_addr  <= 1'b0;
    end else begin
      if (blk_set)      blocked_q <= 1'b1;
      else if (blk_clr) blocked_q <= 1'b0;
      frame_valid <= keep;
      frame_addr  <= keep && is_addr;
      if (keep) begin
        frame_data <= word;
        frame_perr <= perr;
        frame_ferr <= ferr;
      end
    end
  end

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R12
  AST_BLOCKED_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && $past(blocked_q)) |-> frame_addr); // R9
  AST_ADDR_NEEDS_MP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_addr |-> (frame_valid && $past(mp_en))); // R10
  AST_SKIP_DROPS_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && $past(skip_perr)) |-> !frame_perr); // R11
endmodule

// File: rtl/ovs_serial_rx.sv
module ovs_serial_rx
  import ovs_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic [1:0]        os_sel,
  input  logic              vote_off,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        par_sel,
  input  logic [1:0]        stop_sel,
  input  logic              rx_invert,
  input  logic              mp_enable,
  input  logic              mp_addr_bit,
  input  logic              skip_par_err,
  input  logic              block_set,
  input  logic              block_clear,
  output logic              frame_valid,
  output logic [WORD_W-1:0] frame_data,
  output logic              frame_par_err,
  output logic              frame_frm_err,
  output logic              frame_is_addr,
  output logic              rx_idle
);
  logic              s_now, s_prev, s_vote;
  logic              fr_done, fr_perr, fr_ferr;
  logic [WORD_W-1:0] fr_word;

  ovs_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line), .invert(rx_invert), .tick(os_tick),
    .samp_now(s_now), .samp_prev(s_prev), .samp_vote(s_vote));

  ovs_rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .samp_now(s_now), .samp_prev(s_prev),
    .samp_vote(s_vote), .os_sel(os_sel), .vote_off(vote_off), .width_sel(width_sel),
    .par_sel(par_sel), .stop_sel(stop_sel), .done(fr_done), .word(fr_word),
    .perr(fr_perr), .ferr(fr_ferr), .idle(rx_idle));

  ovs_rx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .done(fr_done), .word(fr_word), .perr(fr_perr),
    .ferr(fr_ferr), .blk_set(block_set), .blk_clr(block_clear), .mp_en(mp_enable),
    .mp_bit(mp_addr_bit), .skip_perr(skip_par_err), .frame_valid(frame_valid),
    .frame_data(frame_data), .frame_perr(frame_par_err), .frame_ferr(frame_frm_err),
    .frame_addr(frame_is_addr));
endmodule

// File: tb/test_ovs_serial_rx.sv
`timescale 1ns/1ps
module test_ovs_serial_rx;
  logic       clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, os_tick = 1'b0;
  logic [1:0] os_sel = 2'd0, width_sel = 2'd2, par_sel = 2'd0, stop_sel = 2'd1;
  logic       vote_off = 1'b0, rx_invert = 1'b0, mp_enable = 1'b0, mp_addr_bit = 1'b0;
  logic       skip_par_err = 1'b0, block_set = 1'b0, block_clear = 1'b0;
  logic       frame_valid, frame_par_err, frame_frm_err, frame_is_addr, rx_idle;
  logic [8:0] frame_data;

  ovs_serial_rx i_ovs_serial_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick), .os_sel(os_sel),
    .vote_off(vote_off), .width_sel(width_sel), .par_sel(par_sel), .stop_sel(stop_sel),
    .rx_invert(rx_invert), .mp_enable(mp_enable), .mp_addr_bit(mp_addr_bit),
    .skip_par_err(skip_par_err), .block_set(block_set), .block_clear(block_clear),
    .frame_valid(frame_valid), .frame_data(frame_data), .frame_par_err(frame_par_err),
    .frame_frm_err(frame_frm_err), .frame_is_addr(frame_is_addr), .rx_idle(rx_idle));

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    logic [11:0] fields;  // {addr, ferr, perr, data}
    int          tick;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t it;
  int   n_tests = 0, n_fail = 0, strobes = 0, doubles = 0, tick_no = 0, div_cnt = 0;
  logic prev_valid = 1'b0, blk_m = 1'b0, finished = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin os_tick <= 1'b0; div_cnt <= 0; end
    else begin os_tick <= (div_cnt == 3); div_cnt <= (div_cnt == 3) ? 0 : div_cnt + 1; end
  end
  always @(posedge clk) if (os_tick) tick_no <= tick_no + 1;

  task automatic chk(input logic ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_valid && prev_valid) doubles++;
      prev_valid = frame_valid;
      if (frame_valid) begin
        strobes++;
        if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected strobe", int'(frame_data), 0);
        else begin
          it = exp_q.pop_front();
          chk({frame_is_addr, frame_frm_err, frame_par_err, frame_data} == it.fields, it.tag,
              "frame fields", int'({frame_is_addr, frame_frm_err, frame_par_err, frame_data}),
              int'(it.fields));
          chk(tick_no == it.tick, "R2", "strobe tick", tick_no, it.tick);
        end
      end
    end
  end

  function automatic int ratio_of(input logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 8 : (c == 2) ? 6 : 4;
  endfunction

  // one sample per tick: value set after a tick edge is taken by the next tick
  task automatic put(input logic v);
    rx_line = v ^ rx_invert;
    @(posedge clk);
    while (!os_tick) @(posedge clk);
    #1;
  endtask

  task automatic pulse_block(input logic set);
    @(negedge clk); if (set) block_set = 1'b1; else block_clear = 1'b1;
    @(negedge clk); block_set = 1'b0; block_clear = 1'b0;
    blk_m = set;
  endtask

  task automatic send(input logic [8:0] d, input logic bad_par, input logic stop_v,
                      input int glitch_b, input string tag);
    int n, dl, nb, dec;
    logic pon, p, perr, ferr, addr, keep, v;
    logic [8:0] dm, dexp;
    logic [11:0] seq;
    exp_t e;
    n   = ratio_of(os_sel);
    dl  = (width_sel == 1) ? 7 : (width_sel == 3) ? 9 : 8;
    pon = (par_sel == 2) || (par_sel == 3);
    dec = n / 2 + (vote_off ? 0 : 1);
    dm  = 9'(d & ((32'h1 << dl) - 1));
    p   = (^dm) ^ (par_sel == 3) ^ bad_par;
    nb  = 2 + dl + (pon ? 1 : 0);
    seq = '0;
    for (int i = 0; i < dl; i++) seq[1+i] = dm[i];
    if (pon) seq[1+dl] = p;
    seq[nb-1] = stop_v;
    dexp = dm;
    if (vote_off && glitch_b >= 1 && glitch_b <= dl) dexp[glitch_b-1] = ~dexp[glitch_b-1];
    perr = pon && bad_par;
    ferr = !stop_v && (stop_sel != 0);
    addr = mp_enable && (dexp[8] == mp_addr_bit);
    keep = (!blk_m || addr) && !(skip_par_err && perr);
    repeat (2 * n) put(1'b1);
    for (int b = 0; b < nb; b++) begin
      for (int t = 0; t < n; t++) begin
        v = seq[b];
        if (b == glitch_b && t == n / 2) v = ~v;
        put(v);
        if (b == 0 && t == 0 && keep) begin
          e.fields = {addr, ferr, perr, dexp};
          e.tick   = tick_no + (nb - 1) * n + dec;
          e.tag    = tag;
          exp_q.push_back(e);
        end
      end
    end
    repeat (n) put(1'b1);
  endtask

  int s0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_idle == 1'b1, "R1", "idle after reset", rx_idle, 1);
    chk(frame_valid == 1'b0, "R1", "valid after reset", frame_valid, 0);
    chk(frame_data == 9'h0, "R1", "data after reset", frame_data, 0);

    os_sel = 0; send(9'h0A5, 0, 1, -1, "R2");
    os_sel = 1; send(9'h03C, 0, 1, -1, "R2");
    os_sel = 2; send(9'h05A, 0, 1, -1, "R2");
    os_sel = 3; send(9'h0C3, 0, 1, -1, "R2");

    os_sel = 1;
    width_sel = 1; send(9'h1D5, 0, 1, -1, "R5");
    width_sel = 3; send(9'h1A5, 0, 1, -1, "R5");
    width_sel = 0; send(9'h1FF, 0, 1, -1, "R5");
    width_sel = 2;

    par_sel = 2; send(9'h0B1, 0, 1, -1, "R6"); send(9'h0B1, 1, 1, -1, "R6");
    par_sel = 3; send(9'h0B1, 0, 1, -1, "R6"); send(9'h0B1, 1, 1, -1, "R6");
    par_sel = 0;

    stop_sel = 1; send(9'h066, 0, 0, -1, "R7");
    stop_sel = 0; send(9'h066, 0, 0, -1, "R7");
    stop_sel = 2; send(9'h066, 0, 0, -1, "R7");
    stop_sel = 3; send(9'h066, 0, 1, -1, "R7");
    stop_sel = 1;

    os_sel = 0; send(9'h0A5, 0, 1, 4, "R4");
    vote_off = 1; send(9'h0A5, 0, 1, 4, "R4");
    os_sel = 3; send(9'h096, 0, 1, -1, "R4");
    vote_off = 0; send(9'h096, 0, 1, 2, "R4");

    os_sel = 1; rx_invert = 1; send(9'h0E7, 0, 1, -1, "R8"); rx_invert = 0;

    pulse_block(1);
    s0 = strobes; send(9'h011, 0, 1, -1, "R9");
    chk(strobes == s0, "R9", "blocked frame dropped", strobes, s0);
    pulse_block(0);
    send(9'h022, 0, 1, -1, "R9");

    mp_enable = 1; mp_addr_bit = 1; width_sel = 3;
    pulse_block(1);
    send(9'h1C4, 0, 1, -1, "R10");
    s0 = strobes; send(9'h0C4, 0, 1, -1, "R10");
    chk(strobes == s0, "R10", "non-address dropped while blocked", strobes, s0);
    mp_addr_bit = 0; send(9'h0C4, 0, 1, -1, "R10");
    pulse_block(0);
    mp_addr_bit = 1; send(9'h044, 0, 1, -1, "R10");
    mp_enable = 0; mp_addr_bit = 0; width_sel = 2;

    par_sel = 2; skip_par_err = 1;
    s0 = strobes; send(9'h05C, 1, 1, -1, "R11");
    chk(strobes == s0, "R11", "parity-error frame dropped", strobes, s0);
    send(9'h05C, 0, 1, -1, "R11");
    skip_par_err = 0; par_sel = 0;

    os_sel = 0; vote_off = 0;
    repeat (32) put(1'b1);
    s0 = strobes;
    put(1'b0);
    chk(rx_idle == 1'b0, "R3", "idle drops on start", rx_idle, 0);
    put(1'b0); put(1'b0);
    repeat (8) put(1'b1);
    chk(rx_idle == 1'b1, "R3", "idle after false start", rx_idle, 1);
    repeat (40) put(1'b1);
    chk(strobes == s0, "R3", "no strobe after false start", strobes, s0);

    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R12", "frames outstanding", exp_q.size(), 0);
    chk(doubles == 0, "R12", "strobe longer than one clock", doubles, 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule